// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer with Ready/Busy Status

This block runs the internal programming cycle of a small serial non-volatile memory. The instruction engine hands it one finished program request (word write, word erase, fill-all or clear-all) together with the state of the write-enable latch. The sequencer holds the request until the host drops chip select, then counts a parameterised number of clock cycles that stand in for the cell write time, and finally issues a single commit strobe carrying the word, the address and a whole-array flag. The array itself and the instruction decoder live elsewhere.

While the cycle runs, the host may raise chip select again to poll. Once chip select has been held low for a minimum number of cycles after the cycle began, the data-out line is driven low while busy and high once the commit has happened. The status can be dropped by the host with a serial clock rising edge while chip select and data-in are both high, and it is never shown if the cycle ended while chip select was still low. Each commit writes its final value directly, since the erase before a write is part of the same cycle.

The controller has four states. IDLE waits for a request; the transition accept (request valid with write enable high) leads to ARMED. ARMED waits for chip select to fall: the transition launch leads to BUSY, while the transition abandon (serial clock rising with chip select high) returns to IDLE. BUSY counts the write time; the transition expire leads to COMMIT. COMMIT lasts one cycle, drives the strobe, and the transition retire returns to IDLE.

Top module: `prog_cycle_seq`

## Requirements
- R1: After reset the block is in IDLE: `prog_busy`, `cmt_valid` and `dout_oe` are all 0.
- R2: A request pulse on `req_valid` is taken only when `wr_en` is 1; a request with `wr_en` at 0 is dropped, and a later chip select fall starts no cycle.
- R3: An accepted request starts the cycle only on a falling edge of `cs`; `prog_busy` stays 0 while `cs` stays high, and a rising edge of `sk` sampled with `cs` high before that fall abandons the request.
- R4: `cmt_valid` is 1 for exactly one clock cycle, entered at the clock edge that lies WRITE_CYCLES+1 edges after the first edge that samples `cs` low.
- R5: The commit payload follows `req_kind` (00 word write, 01 word erase, 10 fill-all, 11 clear-all): erase kinds give `cmt_data` all ones, write kinds give the supplied data, `cmt_all` is 1 for kinds 10 and 11, and `cmt_addr` is the request address for word kinds and 0 for array kinds.
- R6: With the status shown (`cs` high), `dout_oe` is 1 and `dout` is 0 while `prog_busy` is 1, and `dout` becomes 1 once the commit is done.
- R7: Status is shown only if `cs` stayed low for at least CS_LOW_CYCLES consecutive samples after the cycle began; otherwise `dout_oe` stays 0 for that cycle.
- R8: If the cycle ends while `cs` is low, no status is kept: a later rise of `cs` leaves `dout_oe` at 0.
- R9: A rising edge of `sk` sampled with `cs` high and `din` high clears the status, so `dout_oe` is 0 from the next cycle; the same edge with `din` low leaves the status in place.
- R10: Requests arriving while a cycle is running are ignored, and each launched cycle produces exactly one commit.
- R11: `dout_oe` is 0 whenever `cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, already synchronised |
| sk | input | 1 | Serial clock level, already synchronised |
| din | input | 1 | Serial data-in level, already synchronised |
| req_valid | input | 1 | One-cycle pulse: a program instruction is fully received |
| req_kind | input | 2 | Program kind: 00 word write, 01 word erase, 10 fill-all, 11 clear-all |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Data word of the request |
| wr_en | input | 1 | State of the write-enable latch |
| prog_busy | output | 1 | Programming cycle in progress |
| cmt_valid | output | 1 | One-cycle commit strobe to the array |
| cmt_all | output | 1 | Commit applies to every word |
| cmt_addr | output | AW | Commit word address |
| cmt_data | output | DW | Commit word value |
| dout | output | 1 | Status bit: 0 busy, 1 ready |
| dout_oe | output | 1 | Drive enable of the status bit |

## Verification
The bench builds the block with WRITE_CYCLES at 40 and CS_LOW_CYCLES at 4, so a full programming cycle spans a few dozen clocks and each commit's arrival edge can be predicted and compared exactly. The short low-time window lets the bench raise chip select both before and after the threshold within one cycle, and the short write time lets it poll busy, see ready, clear the status, and let a cycle finish unobserved, all within a few hundred clocks.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        KIND_WORD_WRITE = 2'b00,
        KIND_WORD_ERASE = 2'b01,
        KIND_FILL_ALL   = 2'b10,
        KIND_CLEAR_ALL  = 2'b11
    } prog_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_BUSY,
        ST_COMMIT
    } psc_state_e;

    function automatic logic kind_is_array(input logic [1:0] kind);
        return kind[1];
    endfunction

    function automatic logic kind_is_erase(input logic [1:0] kind);
        return kind[0];
    endfunction

endpackage

// File: rtl/psc_pin_edges.sv
module psc_pin_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    output logic cs_fall,
    output logic sk_rise
);
    logic cs_q;
    logic sk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            sk_q <= 1'b0;
        end else begin
            cs_q <= cs;
            sk_q <= sk;
        end
    end

    assign cs_fall = cs_q & ~cs;
    assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/psc_timer.sv
module psc_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic reached
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            reached <= 1'b0;
        end else if (restart) begin
            cnt     <= '0;
            reached <= 1'b0;
        end else if (run && !reached) begin
            if (cnt == LAST) begin
                reached <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/psc_status.sv
module psc_status #(
    parameter int LOW_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic start,
    input  logic busy,
    input  logic clear_req,
    output logic dout,
    output logic dout_oe
);
    logic low_ok;
    logic flag;
    logic low_restart;

    assign low_restart = start | (cs & ~low_ok);

    psc_timer #(
        .LIMIT (LOW_CYCLES)
    ) u_low_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (low_restart),
        .run     (~cs),
        .reached (low_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (start) begin
            flag <= 1'b1;
        end else if (clear_req) begin
            flag <= 1'b0;
        end else if (!busy && !cs) begin
            flag <= 1'b0;
        end
    end

    assign dout_oe = cs & flag & low_ok;
    assign dout    = dout_oe & ~busy;
endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq
    import psc_pkg::*;
#(
    parameter int DW            = 16,
    parameter int AW            = 6,
    parameter int WRITE_CYCLES  = 625000,
    parameter int CS_LOW_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          sk,
    input  logic          din,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          wr_en,
    output logic          prog_busy,
    output logic          cmt_valid,
    output logic          cmt_all,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data,
    output logic          dout,
    output logic          dout_oe
);
    psc_state_e    state;
    psc_state_e    state_nx;
    logic          cs_fall;
    logic          sk_rise;
    logic          accept;
    logic          launch;
    logic          wr_done;
    logic          status_clr;
    logic          job_all;
    logic [AW-1:0] job_addr;
    logic [DW-1:0] job_data;

    psc_pin_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .cs_fall (cs_fall),
        .sk_rise (sk_rise)
    );

    psc_timer #(
        .LIMIT (WRITE_CYCLES)
    ) u_write_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .run     (state == ST_BUSY),
        .reached (wr_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: accept, launch, abandon, expire, retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid && wr_en) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_fall) state_nx = ST_BUSY;
                else if (sk_rise && cs) state_nx = ST_IDLE;
            end
            ST_BUSY: begin
                if (wr_done) state_nx = ST_COMMIT;
            end
            ST_COMMIT: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_all  <= 1'b0;
            job_addr <= '0;
            job_data <= '0;
        end else if (accept) begin
            job_all  <= kind_is_array(req_kind);
            job_addr <= kind_is_array(req_kind) ? '0 : req_addr;
            job_data <= kind_is_erase(req_kind) ? '1 : req_data;
        end
    end

    // outputs
    always_comb begin
        accept     = (state == ST_IDLE) && req_valid && wr_en;
        launch     = (state == ST_ARMED) && cs_fall;
        prog_busy  = (state == ST_BUSY) || (state == ST_COMMIT);
        cmt_valid  = (state == ST_COMMIT);
        cmt_all    = job_all;
        cmt_addr   = job_addr;
        cmt_data   = job_data;
        status_clr = sk_rise && cs && din;
    end

    psc_status #(
        .LOW_CYCLES (CS_LOW_CYCLES)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .start     (launch),
        .busy      (prog_busy),
        .clear_req (status_clr),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );
endmodule

// File: rtl/psc_chk.sv
module psc_chk (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic sk,
    input logic din,
    input logic prog_busy,
    input logic cmt_valid,
    input logic dout,
    input logic dout_oe
);
    // R3
    launch_on_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> !$past(cs));

    // R6
    ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(prog_busy) && cs && $past(dout_oe) && !$past(din)) |-> (dout && dout_oe));

    // R8
    idle_low_drops_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_busy && !cs && !$past(cs)) |=> !dout_oe);

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && din && sk && !$past(sk)) |=> !dout_oe);

    // R10
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> !cmt_valid);
endmodule

bind prog_cycle_seq psc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .sk        (sk),
    .din       (din),
    .prog_busy (prog_busy),
    .cmt_valid (cmt_valid),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/prog_cycle_seq_test.sv
module prog_cycle_seq_test;
    localparam int DW = 16;
    localparam int AW = 6;
    localparam int WC = 40;
    localparam int CL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0, sk = 1'b0, din = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          wr_en = 1'b0;
    logic          prog_busy, cmt_valid, cmt_all, dout, dout_oe;
    logic [AW-1:0] cmt_addr;
    logic [DW-1:0] cmt_data;

    prog_cycle_seq #(.DW(DW), .AW(AW), .WRITE_CYCLES(WC), .CS_LOW_CYCLES(CL)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_data(req_data), .wr_en(wr_en), .prog_busy(prog_busy),
        .cmt_valid(cmt_valid), .cmt_all(cmt_all), .cmt_addr(cmt_addr),
        .cmt_data(cmt_data), .dout(dout), .dout_oe(dout_oe)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic          all;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            at;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   commits_seen = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare as commits appear
    always @(negedge clk) begin
        if (rst_n && cmt_valid) begin
            commits_seen++;
            if (sbq.size() == 0) begin
                check(1'b0, "R10", "unexpected commit", 32'(cmt_addr), 32'hffff_ffff);
            end else begin
                mon_e = sbq.pop_front();
                check(cyc == mon_e.at, "R4", "commit cycle", 32'(cyc), 32'(mon_e.at));
                check(cmt_all == mon_e.all, "R5", "whole-array flag", 32'(cmt_all), 32'(mon_e.all));
                check(cmt_addr == mon_e.addr, "R5", "address", 32'(cmt_addr), 32'(mon_e.addr));
                check(cmt_data == mon_e.data, "R5", "data", 32'(cmt_data), 32'(mon_e.data));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_req(input logic [1:0] kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic sk_pulse(input logic d);
        @(negedge clk);
        sk = 1'b1; din = d;
        @(negedge clk);
        sk = 1'b0; din = 1'b0;
    endtask

    // drop cs and, when a cycle should launch, push the expected commit
    task automatic drop_cs(input bit expect_commit, input logic [1:0] kind,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        @(negedge clk);
        cs = 1'b0;
        if (expect_commit) begin
            e.all  = kind[1];
            e.addr = kind[1] ? '0 : a;
            e.data = kind[0] ? '1 : d;
            e.at   = cyc + WC + 2;
            sbq.push_back(e);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1
        check(prog_busy == 1'b0, "R1", "busy after reset", 32'(prog_busy), 0);
        check(cmt_valid == 1'b0, "R1", "strobe after reset", 32'(cmt_valid), 0);
        check(dout_oe == 1'b0, "R1", "status drive after reset", 32'(dout_oe), 0);

        // R2: write-disabled request is dropped
        wr_en = 1'b0;
        cs = 1'b1;
        send_req(2'b00, 6'h11, 16'h5555);
        drop_cs(1'b0, 2'b00, 6'h11, 16'h5555);
        tick(3);
        check(prog_busy == 1'b0, "R2", "no launch when disabled", 32'(prog_busy), 0);
        tick(WC + 4);

        // word write, poll busy and ready, then clear
        wr_en = 1'b1;
        @(negedge clk) cs = 1'b1;
        send_req(2'b00, 6'h2A, 16'h1234);
        tick(3);
        check(prog_busy == 1'b0, "R3", "no launch while cs high", 32'(prog_busy), 0);
        drop_cs(1'b1, 2'b00, 6'h2A, 16'h1234);
        tick(2);
        check(prog_busy == 1'b1, "R3", "launch on cs fall", 32'(prog_busy), 1);
        tick(CL);
        cs = 1'b1;
        tick(2);
        check(dout_oe == 1'b1, "R6", "status driven while busy", 32'(dout_oe), 1);
        check(dout == 1'b0, "R6", "busy reads 0", 32'(dout), 0);
        tick(WC);
        check(prog_busy == 1'b0, "R6", "cycle over", 32'(prog_busy), 0);
        check(dout == 1'b1 && dout_oe == 1'b1, "R6", "ready reads 1", 32'({dout_oe, dout}), 32'h3);
        sk_pulse(1'b0);
        tick(1);
        check(dout_oe == 1'b1, "R9", "din low keeps status", 32'(dout_oe), 1);
        sk_pulse(1'b1);
        tick(1);
        check(dout_oe == 1'b0, "R9", "din high clears status", 32'(dout_oe), 0);
        @(negedge clk) cs = 1'b0;
        tick(3);

        // top address write, then cs low releases and consumes status
        @(negedge clk) cs = 1'b1;
        send_req(2'b00, 6'h3F, 16'h0001);
        drop_cs(1'b1, 2'b00, 6'h3F, 16'h0001);
        tick(CL + 2);
        cs = 1'b1;
        tick(WC + 2);
        check(dout_oe == 1'b1 && dout == 1'b1, "R6", "ready before release", 32'({dout_oe, dout}), 32'h3);
        cs = 1'b0;
        tick(1);
        check(dout_oe == 1'b0, "R11", "cs low releases dout", 32'(dout_oe), 0);
        cs = 1'b1;
        tick(1);
        check(dout_oe == 1'b0, "R8", "status gone after cs low", 32'(dout_oe), 0);
        @(negedge clk) cs = 1'b0;
        tick(3);

        // word erase with cs low for the whole cycle
        @(negedge clk) cs = 1'b1;
        send_req(2'b01, 6'h00, 16'h0F0F);
        drop_cs(1'b1, 2'b01, 6'h00, 16'h0F0F);
        tick(WC + 6);
        cs = 1'b1;
        tick(2);
        check(dout_oe == 1'b0, "R8", "late cs rise shows nothing", 32'(dout_oe), 0);
        @(negedge clk) cs = 1'b0;
        tick(3);

        // fill-all with cs raised too early
        @(negedge clk) cs = 1'b1;
        send_req(2'b10, 6'h15, 16'hA5C3);
        drop_cs(1'b1, 2'b10, 6'h15, 16'hA5C3);
        tick(1);
        cs = 1'b1;
        tick(4);
        check(prog_busy == 1'b1, "R7", "cycle running", 32'(prog_busy), 1);
        check(dout_oe == 1'b0, "R7", "short low time hides busy", 32'(dout_oe), 0);
        tick(WC);
        check(dout_oe == 1'b0, "R7", "short low time hides ready", 32'(dout_oe), 0);
        @(negedge clk) cs = 1'b0;
        tick(3);

        // clear-all with a request arriving mid-cycle
        @(negedge clk) cs = 1'b1;
        send_req(2'b11, 6'h22, 16'h0000);
        drop_cs(1'b1, 2'b11, 6'h22, 16'h0000);
        tick(CL + 2);
        send_req(2'b00, 6'h01, 16'hBEEF);
        cs = 1'b1;
        tick(WC + 4);
        @(negedge clk) cs = 1'b0;
        tick(3);
        check(prog_busy == 1'b0, "R10", "mid-cycle request dropped", 32'(prog_busy), 0);

        // abandon by sk rise before cs falls
        @(negedge clk) cs = 1'b1;
        send_req(2'b00, 6'h07, 16'h7777);
        sk_pulse(1'b0);
        drop_cs(1'b0, 2'b00, 6'h07, 16'h7777);
        tick(3);
        check(prog_busy == 1'b0, "R3", "sk rise abandons request", 32'(prog_busy), 0);
        tick(WC + 4);

        check(sbq.size() == 0, "R4", "pending commits", 32'(sbq.size()), 0);
        check(commits_seen == 5, "R10", "commit count", 32'(commits_seen), 5);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule